// File: doc/BRIEF.md
# Shared interrupt source conditioner

This block sits between a set of external interrupt lines and the routing logic of an interrupt controller. For each line it holds three trigger settings: the sensing mode (level or edge), the polarity, and whether an edge-sensed line reacts to both edges. It turns raw line activity into a pending vector. Raw lines are first brought into the clock domain through two flops. Level-sensed lines pass their polarity-adjusted value straight through. Edge-sensed lines set a sticky latch that only software can clear.

Software reaches the block over a simple 32-bit register bus: word address, write data, write enable, and combinational read data. Each per-line setting lives in a bank that packs 32 lines into a word. Enable masks are never written directly. One bank sets mask bits wherever a one is written, and another bank clears them. A single software edge register can set or clear the latch of any edge-sensed line, chosen by its number. The block drives two vectors: the raw pending vector, and the pending vector qualified by the masks.

Top module: `irq_src_cond`

## Requirements
- R1: After synchronous reset, all masks, edge latches and settings are zero, which means level sensing, active-low, single edge. With every raw line low, every pending bit is therefore 1, every active bit is 0, and the mask words read 0.
- R2: A line whose mode bit is 0 (level) has a pending bit equal to its input after two synchroniser flops, inverted when its polarity bit is 0. The pending bit changes two clock edges after the raw input changes and does not latch.
- R3: A line whose mode bit is 1 (edge) and whose both-edges bit is 0 sets its latch on a rising input when polarity is 1, or on a falling input when polarity is 0. The latch is set three clock edges after the raw change and stays set after the input returns.
- R4: An edge-sensed line whose both-edges bit is 1 sets its latch on either input transition, regardless of polarity. The pending bit of an edge-sensed line is its latch value.
- R5: A write to the software edge register takes the line number from data bits 7:0. Data bit 31 = 1 sets that line's latch and bit 31 = 0 clears it, with effect at that same clock edge. A number at or above the line count changes no line.
- R6: A write to the mask-set bank sets the mask bit of every line whose data bit is 1. A write to the mask-clear bank clears the mask bit of every line whose data bit is 1. Zero data bits leave masks unchanged.
- R7: The word address is bank in bits 5:3 and word in bits 2:0. The banks are 0 mode, 1 polarity, 2 both-edges, 3 mask-clear, 4 mask-set, 5 mask readback, 6 pending readback and 7 software edge. Line i sits in word i/32 at bit i%32. The mask-clear, mask-set and software edge banks, bits for lines at or above the count, and unused words all read 0.
- R8: Each active output bit is the pending bit ANDed with that line's mask bit.
- R9: When a hardware edge and a software clear of the same line's latch fall on the same clock edge, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register word address (bank in 5:3, word in 2:0) |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_raw | input | NUM_IRQ | Asynchronous raw interrupt lines |
| irq_pend | output | NUM_IRQ | Pending vector |
| irq_active | output | NUM_IRQ | Pending and unmasked vector |

## Verification
The bench targets the synchroniser depth by sampling one edge before the level result is due and again when it is due. A design with a missing or extra flop would report the change a cycle early or late. It places a hardware edge on exactly the same clock edge as a software clear of that line. A design with the wrong priority would drop the interrupt. It writes software edge numbers above the line count, including one whose low bits alias a real line, and a design that decoded too few bits would clear that line. Mask writes with zero bits, a falling edge in both-edge mode, and pending bits that stay set after the line returns catch a mask bank that overwrites instead of merging, a both-edge mode that only sees one direction, and level logic leaking into the edge latch.

// File: rtl/irq_src_cond_pkg.sv
package irq_src_cond_pkg;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 6;
    localparam int SW_NUM_W   = 8;
    localparam int SW_SET_BIT = 31;

    typedef enum logic [2:0] {
        BK_MODE   = 3'd0,
        BK_POL    = 3'd1,
        BK_BOTH   = 3'd2,
        BK_MCLR   = 3'd3,
        BK_MSET   = 3'd4,
        BK_MASK   = 3'd5,
        BK_PEND   = 3'd6,
        BK_SWEDGE = 3'd7
    } bank_e;

    typedef struct packed {
        logic edge_md;
        logic pol;
        logic both;
    } line_cfg_t;

    typedef struct packed {
        logic set;
        logic clr;
    } sw_cmd_t;

    function automatic int words_for(input int n);
        return (n + WORD_W - 1) / WORD_W;
    endfunction
endpackage

// File: rtl/irq_src_line.sv
module irq_src_line
    import irq_src_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      raw_in,
    input  line_cfg_t cfg,
    input  sw_cmd_t   sw,
    output logic      pend_out
);
    logic [1:0] sync_q;
    logic       prev_q;
    logic       latch_q;
    logic       rise;
    logic       fall;
    logic       hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '0;
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_in};
            prev_q <= sync_q[1];
            // hardware edge outranks a software clear in the same cycle
            if (hit)
                latch_q <= 1'b1;
            else if (sw.clr)
                latch_q <= 1'b0;
            else if (sw.set)
                latch_q <= 1'b1;
        end
    end

    always_comb begin
        rise = sync_q[1] & ~prev_q;
        fall = ~sync_q[1] & prev_q;
        if (!cfg.edge_md)
            hit = 1'b0;
        else if (cfg.both)
            hit = rise | fall;
        else
            hit = cfg.pol ? rise : fall;
        pend_out = cfg.edge_md ? latch_q : (sync_q[1] == cfg.pol);
    end
endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_src_cond_pkg::*;
#(
    parameter int NUM_IRQ = 40
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    input  logic                   bus_we,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic [NUM_IRQ-1:0]     pend_in,
    output line_cfg_t [NUM_IRQ-1:0] cfg_out,
    output sw_cmd_t   [NUM_IRQ-1:0] sw_out,
    output logic [NUM_IRQ-1:0]     mask_out
);
    localparam int NW   = words_for(NUM_IRQ);
    localparam int PADW = NW * WORD_W;

    bank_e                bank;
    logic [2:0]           widx;
    logic [SW_NUM_W-1:0]  sw_num;
    logic                 sw_wr;
    logic [NUM_IRQ-1:0]   mode_v;
    logic [NUM_IRQ-1:0]   pol_v;
    logic [NUM_IRQ-1:0]   both_v;
    logic [PADW-1:0]      mode_p;
    logic [PADW-1:0]      pol_p;
    logic [PADW-1:0]      both_p;
    logic [PADW-1:0]      mask_p;
    logic [PADW-1:0]      pend_p;

    assign bank   = bank_e'(bus_addr[5:3]);
    assign widx   = bus_addr[2:0];
    assign sw_num = bus_wdata[SW_NUM_W-1:0];
    assign sw_wr  = bus_we && (bank == BK_SWEDGE);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        localparam int W = i / WORD_W;
        localparam int B = i % WORD_W;

        logic wsel;
        logic mode_q;
        logic pol_q;
        logic both_q;
        logic mask_q;
        logic num_hit;

        assign wsel    = bus_we && (widx == 3'(W));
        assign num_hit = sw_wr && (sw_num == SW_NUM_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                mode_q <= 1'b0;
                pol_q  <= 1'b0;
                both_q <= 1'b0;
                mask_q <= 1'b0;
            end else if (wsel) begin
                if (bank == BK_MODE) mode_q <= bus_wdata[B];
                if (bank == BK_POL)  pol_q  <= bus_wdata[B];
                if (bank == BK_BOTH) both_q <= bus_wdata[B];
                if (bank == BK_MSET && bus_wdata[B])
                    mask_q <= 1'b1;
                else if (bank == BK_MCLR && bus_wdata[B])
                    mask_q <= 1'b0;
            end
        end

        assign mode_v[i]         = mode_q;
        assign pol_v[i]          = pol_q;
        assign both_v[i]         = both_q;
        assign mask_out[i]       = mask_q;
        assign cfg_out[i].edge_md = mode_q;
        assign cfg_out[i].pol    = pol_q;
        assign cfg_out[i].both   = both_q;
        assign sw_out[i].set     = num_hit && bus_wdata[SW_SET_BIT];
        assign sw_out[i].clr     = num_hit && !bus_wdata[SW_SET_BIT];
    end

    assign mode_p = PADW'(mode_v);
    assign pol_p  = PADW'(pol_v);
    assign both_p = PADW'(both_v);
    assign mask_p = PADW'(mask_out);
    assign pend_p = PADW'(pend_in);

    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NW; w++) begin
            if (widx == 3'(w)) begin
                case (bank)
                    BK_MODE: bus_rdata = mode_p[w*WORD_W +: WORD_W];
                    BK_POL:  bus_rdata = pol_p[w*WORD_W +: WORD_W];
                    BK_BOTH: bus_rdata = both_p[w*WORD_W +: WORD_W];
                    BK_MASK: bus_rdata = mask_p[w*WORD_W +: WORD_W];
                    BK_PEND: bus_rdata = pend_p[w*WORD_W +: WORD_W];
                    default: bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/irq_src_cond.sv
module irq_src_cond
    import irq_src_cond_pkg::*;
#(
    parameter int NUM_IRQ = 40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [5:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_we,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_raw,
    output logic [NUM_IRQ-1:0] irq_pend,
    output logic [NUM_IRQ-1:0] irq_active
);
    line_cfg_t [NUM_IRQ-1:0] cfg_v;
    sw_cmd_t   [NUM_IRQ-1:0] sw_v;
    logic      [NUM_IRQ-1:0] mask_v;
    logic      [NUM_IRQ-1:0] edge_v;

    irq_src_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pend_in   (irq_pend),
        .cfg_out   (cfg_v),
        .sw_out    (sw_v),
        .mask_out  (mask_v)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        irq_src_line u_line (
            .clk      (clk),
            .rst      (rst),
            .raw_in   (irq_raw[i]),
            .cfg      (cfg_v[i]),
            .sw       (sw_v[i]),
            .pend_out (irq_pend[i])
        );
        assign edge_v[i] = cfg_v[i].edge_md;
    end

    assign irq_active = irq_pend & mask_v;
endmodule

// File: rtl/irq_src_cond_chk.sv
module irq_src_cond_chk #(
    parameter int NUM_IRQ = 40
) (
    input logic               clk,
    input logic               rst,
    input logic [5:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               bus_we,
    input logic [NUM_IRQ-1:0] irq_pend,
    input logic [NUM_IRQ-1:0] irq_active,
    input logic [NUM_IRQ-1:0] mask_v,
    input logic [NUM_IRQ-1:0] edge_v
);
    // R8: nothing is active that is not pending
    p_active_in_pend_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_active & ~irq_pend) == '0);

    // R6: a one written to the set bank turns line 0 on
    p_mask_set_r6: assert property (@(posedge clk) disable iff (rst)
        bus_we && bus_addr == 6'b100_000 && bus_wdata[0] |=> mask_v[0]);

    // R6: a one written to the clear bank turns line 0 off
    p_mask_clr_r6: assert property (@(posedge clk) disable iff (rst)
        bus_we && bus_addr == 6'b011_000 && bus_wdata[0] |=> !mask_v[0]);

    // R5: software set of line 0 in edge mode makes it pending
    p_sw_set_r5: assert property (@(posedge clk) disable iff (rst)
        bus_we && bus_addr[5:3] == 3'd7 && bus_wdata[31] &&
        bus_wdata[7:0] == 8'd0 && edge_v[0] |=> irq_pend[0]);

    // R3: a latched edge stays pending while nothing is written
    p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
        edge_v[0] && irq_pend[0] && !bus_we |=> irq_pend[0]);
endmodule

bind irq_src_cond irq_src_cond_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_we     (bus_we),
    .irq_pend   (irq_pend),
    .irq_active (irq_active),
    .mask_v     (mask_v),
    .edge_v     (edge_v)
);

// File: tb/test_irq_src_cond.sv
`timescale 1ns/1ps
module test_irq_src_cond;
    localparam int N = 40;
    localparam logic [N-1:0] ALL = {N{1'b1}};

    logic         clk = 1'b0;
    logic         rst;
    logic [5:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic         bus_we;
    logic [31:0]  bus_rdata;
    logic [N-1:0] irq_raw;
    logic [N-1:0] irq_pend;
    logic [N-1:0] irq_active;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    bit run   = 1'b0;

    always #10 clk = ~clk;

    irq_src_cond #(.NUM_IRQ(N)) i_irq_src_cond (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .bus_rdata  (bus_rdata),
        .irq_raw    (irq_raw),
        .irq_pend   (irq_pend),
        .irq_active (irq_active)
    );

    // behavioural reference state
    bit m_s1 [N];
    bit m_s2 [N];
    bit m_pv [N];
    bit m_lt [N];
    bit m_md [N];
    bit m_po [N];
    bit m_bo [N];
    bit m_mk [N];

    function automatic bit mp(input int i);
        if (m_md[i]) return m_lt[i];
        return m_po[i] ? m_s2[i] : !m_s2[i];
    endfunction

    function automatic logic [N-1:0] m_pend_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = mp(i);
        return v;
    endfunction

    function automatic logic [N-1:0] m_act_vec();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = mp(i) && m_mk[i];
        return v;
    endfunction

    function automatic logic [31:0] m_rd(input logic [5:0] a);
        logic [31:0] v;
        v = '0;
        for (int b = 0; b < 32; b++) begin
            int i;
            i = int'(a[2:0]) * 32 + b;
            if (i < N) begin
                case (a[5:3])
                    3'd0: v[b] = m_md[i];
                    3'd1: v[b] = m_po[i];
                    3'd2: v[b] = m_bo[i];
                    3'd5: v[b] = m_mk[i];
                    3'd6: v[b] = mp(i);
                    default: v[b] = 1'b0;
                endcase
            end
        end
        return v;
    endfunction

    always @(posedge clk) begin
        int num;
        bit r;
        bit f;
        bit h;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_pv[i] = 0; m_lt[i] = 0;
                m_md[i] = 0; m_po[i] = 0; m_bo[i] = 0; m_mk[i] = 0;
            end
        end else begin
            num = int'(bus_wdata[7:0]);
            for (int i = 0; i < N; i++) begin
                r = m_s2[i] && !m_pv[i];
                f = !m_s2[i] && m_pv[i];
                h = m_md[i] && (m_bo[i] ? (r || f) : (m_po[i] ? r : f));
                if (h)
                    m_lt[i] = 1;
                else if (bus_we && bus_addr[5:3] == 3'd7 && num == i)
                    m_lt[i] = bus_wdata[31];
                m_pv[i] = m_s2[i];
                m_s2[i] = m_s1[i];
                m_s1[i] = irq_raw[i];
            end
            if (bus_we) begin
                for (int b = 0; b < 32; b++) begin
                    int i;
                    i = int'(bus_addr[2:0]) * 32 + b;
                    if (i < N) begin
                        case (bus_addr[5:3])
                            3'd0: m_md[i] = bus_wdata[b];
                            3'd1: m_po[i] = bus_wdata[b];
                            3'd2: m_bo[i] = bus_wdata[b];
                            3'd3: if (bus_wdata[b]) m_mk[i] = 0;
                            3'd4: if (bus_wdata[b]) m_mk[i] = 1;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (run && !rst) begin
            chk("R2/R3/R4 pending vs model", 64'(irq_pend), 64'(m_pend_vec()));
            chk("R8 active vs model", 64'(irq_active), 64'(m_act_vec()));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic swe(input bit set, input logic [7:0] num);
        wr({3'd7, 3'd0}, {set, 23'd0, num});
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [N-1:0] saved;
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; irq_raw = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pending all ones after reset", 64'(irq_pend), 64'(ALL));
        chk("R1 active all zero after reset", 64'(irq_active), 64'd0);
        rd_chk("R1 mask word0 after reset", {3'd5, 3'd0}, 32'h0);
        rd_chk("R1 mode word1 after reset", {3'd0, 3'd1}, 32'h0);

        // R6 masks
        wr({3'd4, 3'd0}, 32'hFFFF_FFFF);
        wr({3'd4, 3'd1}, 32'h0000_00FF);
        chk("R8 all lines active", 64'(irq_active), 64'(ALL));
        wr({3'd3, 3'd0}, 32'h0000_00F0);
        rd_chk("R6 mask word0 after clear", {3'd5, 3'd0}, 32'hFFFF_FF0F);
        wr({3'd4, 3'd0}, 32'h0);
        rd_chk("R6 zero set bits leave mask", {3'd5, 3'd0}, 32'hFFFF_FF0F);
        wr({3'd3, 3'd1}, 32'h0);
        rd_chk("R6 zero clear bits leave mask", {3'd5, 3'd1}, 32'h0000_00FF);
        chk("R8 masked lines inactive", 64'(irq_active[7:4]), 64'd0);

        // R2 level mode, lines 0-3 active high
        wr({3'd1, 3'd0}, 32'h0000_000F);
        irq_raw[0] = 1'b1;
        irq_raw[4] = 1'b1;
        @(negedge clk);
        chk("R2 no change after one edge", 64'(irq_pend[7:0]), 64'hF0);
        @(negedge clk);
        chk("R2 level follows after two edges", 64'(irq_pend[7:0]), 64'hE1);
        irq_raw[0] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 level does not latch", 64'(irq_pend[0]), 64'd0);

        // R3/R4 edge modes on lines 8-19
        wr({3'd0, 3'd0}, 32'h000F_FF00);
        wr({3'd1, 3'd0}, 32'h0000_0F0F);
        wr({3'd2, 3'd0}, 32'h000F_0000);
        chk("R3 edge latches clear on mode entry", 64'(irq_pend[19:8]), 64'h000);
        irq_raw[8] = 1'b1; irq_raw[12] = 1'b1; irq_raw[16] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 no latch before third edge", 64'(irq_pend[19:8]), 64'h000);
        @(negedge clk);
        chk("R3 rising and R4 both-edge latch", 64'(irq_pend[19:8]), 64'h101);
        irq_raw[8] = 1'b0; irq_raw[12] = 1'b0; irq_raw[16] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 falling latch and hold", 64'(irq_pend[19:8]), 64'h111);

        // R5 software clear, R4 falling edge in both-edge mode
        swe(1'b0, 8'd16);
        chk("R5 software clear line 16", 64'(irq_pend[16]), 64'd0);
        irq_raw[16] = 1'b1;
        repeat (3) @(negedge clk);
        swe(1'b0, 8'd16);
        irq_raw[16] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 falling edge latches in both-edge mode", 64'(irq_pend[16]), 64'd1);

        // R5 software set in word 1, out-of-range numbers
        wr({3'd0, 3'd1}, 32'h0000_0080);
        swe(1'b1, 8'd39);
        chk("R5 software set line 39", 64'(irq_pend[39]), 64'd1);
        saved = irq_pend;
        swe(1'b1, 8'd45);
        swe(1'b0, 8'd167);
        swe(1'b0, 8'd200);
        chk("R5 out-of-range numbers ignored", 64'(irq_pend), 64'(saved));

        // R9 hardware edge and software clear on the same edge
        swe(1'b0, 8'd8);
        chk("R5 software clear line 8", 64'(irq_pend[8]), 64'd0);
        irq_raw[8] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        swe(1'b0, 8'd8);
        chk("R9 hardware edge wins over clear", 64'(irq_pend[8]), 64'd1);

        // R7 readback layout
        rd_chk("R7 mode word0", {3'd0, 3'd0}, 32'h000F_FF00);
        rd_chk("R7 polarity word0", {3'd1, 3'd0}, 32'h0000_0F0F);
        rd_chk("R7 both-edges word0", {3'd2, 3'd0}, 32'h000F_0000);
        rd_chk("R7 mode word1", {3'd0, 3'd1}, 32'h0000_0080);
        rd_chk("R7 mask-clear reads zero", {3'd3, 3'd0}, 32'h0);
        rd_chk("R7 mask-set reads zero", {3'd4, 3'd0}, 32'h0);
        rd_chk("R7 software edge reads zero", {3'd7, 3'd0}, 32'h0);
        rd_chk("R7 unused word reads zero", {3'd5, 3'd2}, 32'h0);
        rd_chk("R7 pending word1", {3'd6, 3'd1}, {24'd0, irq_pend[39:32]});
        rd_chk("R7 pending word0 vs model", {3'd6, 3'd0}, m_rd({3'd6, 3'd0}));

        // mixed traffic, compared every cycle with the model
        for (int k = 0; k < 400; k++) begin
            irq_raw = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) begin
                logic [5:0] a;
                a = {3'($urandom_range(0, 7)), 3'($urandom_range(0, 2))};
                wr(a, $urandom);
            end else if ($urandom_range(0, 3) == 0) begin
                swe(1'($urandom), 8'($urandom_range(0, 63)));
            end else begin
                @(negedge clk);
            end
            if (k % 40 == 0) begin
                logic [5:0] ra;
                ra = 6'($urandom);
                rd_chk("R7 random readback vs model", ra, m_rd(ra));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule